// File: doc/BRIEF.md
# Port Event Collector and Host Interrupt Controller

This block gathers fault and status events reported by eight port controllers into one sticky 7-bit event register per port. A register is cleared by reading it through the host register path. A single global mask, shared by all ports, selects which event kinds may request service. The block builds an 8-bit service-request vector with one bit per port and drives an active-low, open-drain style interrupt toward the host.

The interrupt is withdrawn in two ways. A read of any event register withdraws it. Winning arbitration for the alert-response address also withdraws it, and in that case the block additionally clears its interrupt enable, so the line stays released until the host sets the enable again. The block also forms the 7-bit bus address that it returns during the alert response. This address is a fixed `10` prefix followed by five strap inputs. The serial bit engine and the port state machines lie outside this block.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, every event register reads 0, the mask reads 7'h7F (all masked), the interrupt enable reads 1, `srq_o` is 0 and `irq_no` is 1.
- R2: A 1 on `evt_set_i[p*7+b]` sets bit b of port p's event register at the next edge, and that bit stays set until the register is read. The bit positions are: 6 power denied, 5 valid signature, 4 invalid signature, 3 short circuit, 2 overload, 1 DC hold-signature lost, 0 AC hold-signature lost. `rd_data_o[7]` is always 0.
- R3: `rd_data_o` shows the register of the port selected by `rd_sel_i` in the same cycle. When `rd_evt_i` is 1, that register is zero after the edge.
- R4: An event pulse that arrives in the same cycle as a clearing read of its port survives the read.
- R5: A mask bit of 1 blocks that event kind on every port. `srq_o[p]` is 1 exactly when port p holds an event whose mask bit is 0. Port 1 maps to bit 0. Masked events are still recorded.
- R6: `irq_no` goes low at the second edge after an unmasked event pulse, provided the interrupt enable is 1. It never goes low while nothing is unmasked and pending.
- R7: An event-register read drives `irq_no` high at the next edge. If another port still holds an unmasked event, the interrupt returns one edge later.
- R8: `ara_won_i` clears the interrupt enable and drives `irq_no` high at the next edge. The line stays high with events pending until the host writes 1 to the enable, and it goes low two edges after that write. If the host writes the enable in the same cycle as `ara_won_i`, the alert-response clear takes priority.
- R9: `dev_addr_o` equals {1, 0, strap_i[4:0]}, where `strap_i[4]` is the most significant strap bit.
- R10: A read of one port leaves every other port's event register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | 56 | Event pulses, 7 bits per port, port p at [p*7+6:p*7] |
| rd_evt_i | input | 1 | Clearing read strobe for the selected port |
| rd_sel_i | input | 3 | Port index for reads (0 = port 1) |
| rd_data_o | output | 8 | Selected port's event register, bit 7 zero |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 7 | New mask value |
| mask_o | output | 7 | Current mask |
| irq_en_we_i | input | 1 | Interrupt-enable write strobe |
| irq_en_wdata_i | input | 1 | New interrupt-enable value |
| irq_en_o | output | 1 | Current interrupt enable |
| ara_won_i | input | 1 | Alert-response arbitration won |
| strap_i | input | 5 | Address strap pins, bit 4 most significant |
| dev_addr_o | output | 7 | Device bus address |
| srq_o | output | 8 | Per-port service request |
| irq_no | output | 1 | Interrupt, low = asserted (drive-low enable of the pad) |

## Verification
The main function is driven by a vector walk. The walk puts single and multiple event bits on every port in turn with the mask open. This shows that each bit lands at its own position, that each port reaches its own `srq_o` bit, and that one read both returns and clears the register. Directed cases follow. A fully masked burst tells recording apart from requesting. Coincident pulse and read tells a dropped event from a kept one. Two pending ports tell a read-release from a full release. An alert-response win with events still pending tells the enable latch apart from plain event clearing.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int EVT_W = 7;

  typedef enum int {
    EV_AC_HOLD_LOST = 0,
    EV_DC_HOLD_LOST = 1,
    EV_OVERLOAD     = 2,
    EV_SHORT        = 3,
    EV_SIG_BAD      = 4,
    EV_SIG_GOOD     = 5,
    EV_PWR_DENIED   = 6
  } evt_bit_e;

  localparam logic [1:0] ADDR_PREFIX = 2'b10;
  localparam logic [EVT_W-1:0] MASK_RST = '1;
endpackage

// File: rtl/evt_port_reg.sv
module evt_port_reg #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] evt_q;

  // set wins over clear so a coincident pulse is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (clr_i ? '0 : evt_q) | set_i;
  end

  assign evt_o = evt_q;

  p_keep_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((evt_q & $past(set_i)) == $past(set_i)));

  p_rd_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (evt_q == '0));

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && set_i == '0) |=> $stable(evt_q));
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic rd_any_i,
  input  logic ara_won_i,
  input  logic en_we_i,
  input  logic en_wdata_i,
  output logic en_o,
  output logic irq_no
);
  logic en_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      if (ara_won_i)    en_q <= 1'b0;
      else if (en_we_i) en_q <= en_wdata_i;
      irq_q <= en_q & pend_i & ~(rd_any_i | ara_won_i);
    end
  end

  assign en_o   = en_q;
  assign irq_no = ~irq_q;

  p_ara_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ara_won_i |=> (!en_q && irq_no));

  p_rd_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_any_i |=> irq_no);

  p_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> $past(en_q));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int STRAP_W   = 5,
  localparam int SEL_W    = $clog2(NUM_PORTS),
  localparam int DATA_W   = EVT_W + 1,
  localparam int ADDR_W   = STRAP_W + 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PORTS*EVT_W-1:0] evt_set_i,
  input  logic                       rd_evt_i,
  input  logic [SEL_W-1:0]           rd_sel_i,
  output logic [DATA_W-1:0]          rd_data_o,
  input  logic                       mask_we_i,
  input  logic [EVT_W-1:0]           mask_wdata_i,
  output logic [EVT_W-1:0]           mask_o,
  input  logic                       irq_en_we_i,
  input  logic                       irq_en_wdata_i,
  output logic                       irq_en_o,
  input  logic                       ara_won_i,
  input  logic [STRAP_W-1:0]         strap_i,
  output logic [ADDR_W-1:0]          dev_addr_o,
  output logic [NUM_PORTS-1:0]       srq_o,
  output logic                       irq_no
);
  logic [EVT_W-1:0] mask_q;
  logic [EVT_W-1:0] evt_w [NUM_PORTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= MASK_RST;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end
  assign mask_o = mask_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    evt_port_reg #(.W(EVT_W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt_set_i[p*EVT_W +: EVT_W]),
      .clr_i (rd_evt_i && rd_sel_i == SEL_W'(p)),
      .evt_o (evt_w[p])
    );
    assign srq_o[p] = |(evt_w[p] & ~mask_q);
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rd_sel_i == SEL_W'(p)) rd_data_o = {1'b0, evt_w[p]};
  end

  assign dev_addr_o = {ADDR_PREFIX, strap_i};

  evt_irq_gen u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (|srq_o),
    .rd_any_i  (rd_evt_i),
    .ara_won_i (ara_won_i),
    .en_we_i   (irq_en_we_i),
    .en_wdata_i(irq_en_wdata_i),
    .en_o      (irq_en_o),
    .irq_no    (irq_no)
  );

  p_idle_no_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srq_o == '0) |=> irq_no);

  p_mask_hides_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == MASK_RST) |-> (srq_o == '0));
endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [55:0] evt_set_i = '0;
  logic        rd_evt_i = 1'b0;
  logic [2:0]  rd_sel_i = '0;
  logic [7:0]  rd_data_o;
  logic        mask_we_i = 1'b0;
  logic [6:0]  mask_wdata_i = '0;
  logic [6:0]  mask_o;
  logic        irq_en_we_i = 1'b0;
  logic        irq_en_wdata_i = 1'b0;
  logic        irq_en_o;
  logic        ara_won_i = 1'b0;
  logic [4:0]  strap_i = '0;
  logic [6:0]  dev_addr_o;
  logic [7:0]  srq_o;
  logic        irq_no;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  evt_irq_ctrl dut_i (.*);

  // entry: {port[2:0], bits[6:0], expected read byte[7:0]}
  localparam logic [17:0] VEC [8] = '{
    {3'd0, 7'h01, 8'h01}, {3'd1, 7'h02, 8'h02},
    {3'd2, 7'h0C, 8'h0C}, {3'd3, 7'h10, 8'h10},
    {3'd4, 7'h20, 8'h20}, {3'd5, 7'h40, 8'h40},
    {3'd6, 7'h7F, 8'h7F}, {3'd7, 7'h55, 8'h55}
  };

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse(int port, logic [6:0] bits);
    evt_set_i[port*7 +: 7] = bits;
    step();
    evt_set_i = '0;
  endtask

  task automatic rd_clear(int port);
    rd_sel_i = 3'(port);
    rd_evt_i = 1'b1;
    step();
    rd_evt_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    #1;
    chk("R1 srq", 32'(srq_o), 0);
    chk("R1 irq", 32'(irq_no), 1);
    chk("R1 mask", 32'(mask_o), 32'h7F);
    chk("R1 en", 32'(irq_en_o), 1);
    chk("R1 rd", 32'(rd_data_o), 0);

    // R5 masked events still recorded, no request
    pulse(0, 7'h7F);
    #1 chk("R5 masked srq", 32'(srq_o), 0);
    step();
    chk("R5 masked irq", 32'(irq_no), 1);
    rd_sel_i = 3'd0; #1;
    chk("R5 masked recorded", 32'(rd_data_o), 32'h7F);
    rd_clear(0);
    mask_wdata_i = 7'h00; mask_we_i = 1'b1;
    step();
    mask_we_i = 1'b0;
    chk("R5 mask write", 32'(mask_o), 0);

    // vector walk: R2 R3 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      int port;
      port = int'(VEC[i][17:15]);
      pulse(port, VEC[i][14:8]);
      #1;
      chk("R5 srq port", 32'(srq_o), 32'(8'(1) << port));
      chk("R6 irq not yet", 32'(irq_no), 1);
      step();
      chk("R6 irq low", 32'(irq_no), 0);
      rd_sel_i = 3'(port); rd_evt_i = 1'b1; #1;
      chk("R2 R3 read data", 32'(rd_data_o), 32'(VEC[i][7:0]));
      step();
      rd_evt_i = 1'b0; #1;
      chk("R3 cleared", 32'(rd_data_o), 0);
      chk("R3 srq cleared", 32'(srq_o), 0);
      chk("R7 irq released", 32'(irq_no), 1);
    end

    // R5 partial mask: only bit 0 open
    mask_wdata_i = 7'h7E; mask_we_i = 1'b1;
    step();
    mask_we_i = 1'b0;
    pulse(4, 7'h08);
    #1 chk("R5 short masked", 32'(srq_o), 0);
    pulse(4, 7'h01);
    #1 chk("R5 ac open", 32'(srq_o), 32'h10);
    rd_sel_i = 3'd4; #1;
    chk("R5 both kept", 32'(rd_data_o), 32'h09);
    rd_clear(4);
    mask_wdata_i = 7'h00; mask_we_i = 1'b1;
    step();
    mask_we_i = 1'b0;

    // R4 coincident pulse and read
    pulse(1, 7'h20);
    rd_sel_i = 3'd1; rd_evt_i = 1'b1;
    evt_set_i[7 +: 7] = 7'h04; #1;
    chk("R4 old data", 32'(rd_data_o), 32'h20);
    step();
    rd_evt_i = 1'b0; evt_set_i = '0; #1;
    chk("R4 pulse kept", 32'(rd_data_o), 32'h04);
    rd_clear(1);

    // R10 read of another port
    pulse(3, 7'h12);
    rd_clear(2);
    rd_sel_i = 3'd3; #1;
    chk("R10 untouched", 32'(rd_data_o), 32'h12);
    rd_clear(3);
    step(); step();

    // R7 two ports pending
    evt_set_i[2*7 +: 7] = 7'h02;
    evt_set_i[5*7 +: 7] = 7'h40;
    step();
    evt_set_i = '0;
    step();
    chk("R7 irq low", 32'(irq_no), 0);
    rd_clear(2);
    chk("R7 released by read", 32'(irq_no), 1);
    step();
    chk("R7 returns for port 6", 32'(irq_no), 0);
    rd_clear(5);
    step();
    chk("R7 stays released", 32'(irq_no), 1);

    // R8 alert response
    pulse(7, 7'h10);
    step();
    chk("R8 irq low", 32'(irq_no), 0);
    ara_won_i = 1'b1; irq_en_we_i = 1'b1; irq_en_wdata_i = 1'b1;
    step();
    ara_won_i = 1'b0; irq_en_we_i = 1'b0;
    chk("R8 irq high", 32'(irq_no), 1);
    chk("R8 en cleared", 32'(irq_en_o), 0);
    repeat (4) step();
    chk("R8 stays off", 32'(irq_no), 1);
    chk("R8 still pending", 32'(srq_o), 32'h80);
    irq_en_we_i = 1'b1; irq_en_wdata_i = 1'b1;
    step();
    irq_en_we_i = 1'b0;
    chk("R8 en set", 32'(irq_en_o), 1);
    chk("R8 not yet", 32'(irq_no), 1);
    step();
    chk("R8 re-armed", 32'(irq_no), 0);
    rd_clear(7);

    // R9 address
    strap_i = 5'b10110; #1;
    chk("R9 addr a", 32'(dev_addr_o), 32'b1010110);
    strap_i = 5'b00001; #1;
    chk("R9 addr b", 32'(dev_addr_o), 32'b1000001);
    strap_i = 5'b11111; #1;
    chk("R9 addr c", 32'(dev_addr_o), 32'b1011111);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule